// File: doc/BRIEF.md
# ATAPI device-side host port

This block sits at the device end of a parallel IDE/ATAPI cable. The host reaches a small set of task registers through two active-low chip selects (command block and control block), a 3-bit address and active-low read and write strobes. The host strobes are synchronized into the device clock and edge-detected, so each strobe performs exactly one access. Register accesses use the low byte of the 16-bit bus. Accesses to the data port use all 16 bits.

Writes to the data port fill a 12-byte command packet buffer, which the internal side then drains one byte at a time over a valid/ready port. The internal side also pushes 16-bit words into a data FIFO. The host pulls these words either with programmed I/O reads of the data port, or with an interlocked DMA request/acknowledge handshake. The block also drives an activity indication and gates the interrupt line through an output enable.

Top module: `atapi_dev_port`

## Requirements
- R1: After reset the status register (command block address 7) reads 0x0040. The status bits are BSY at bit 7, DRDY at bit 6 (always 1) and DRQ at bit 3. After reset dmarq, intrq_oe and pkt_valid are 0 and dat_ready is 1.
- R2: Register reads return the register in bits 7:0, with bits 15:8 at zero. Addresses 2, 4 and 5 of the command block are plain byte registers that keep only bits 7:0 of a write. Address 1 reads as 0x0000.
- R3: Reads of the data port (command block, address 0) return the data FIFO words in the order they were pushed, all 16 bits.
- R4: The DRQ status bit is 1 exactly while the data FIFO holds at least one word. The alternate status register (control block, address 6) reads the same value as status.
- R5: A packet is six data-port writes, low byte first. pkt_valid stays 0 until the sixth write. The bytes then leave on pkt_byte in arrival order, one per cycle with pkt_ready high, and pkt_valid falls after the twelfth byte.
- R6: BSY is set by the sixth packet word and cleared only by a pkt_done pulse. Data-port writes made while BSY is set change nothing.
- R7: A strobe that is held low for many cycles performs one access only. A long data-port read removes a single word.
- R8: When features bit 0 is 1 and the data FIFO holds data, dmarq rises and stays high until dmack_n has been seen low, and only then falls. A DMA read returns the next FIFO word. After dmack_n goes high again, dmarq rises again only if words remain.
- R9: intrq_oe is 1 only when nIEN (bit 1 of the device-control register, control block address 6) is 0 and drive-register bit 4 equals DEV_ID. It follows a device-control write one clock after the register changes. nIEN resets to 1. A deselected device does not drive dd_oe on reads.
- R10: intrq goes high when pkt_done ends a busy packet. A read of status clears it. A read of alternate status leaves it set.
- R11: dasp_n is low while BSY or DRQ is set, and high otherwise.
- R12: dat_ready is 0 while the data FIFO holds DF_DEPTH words. A push made while it is 0 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low reset |
| cs0_n | input | 1 | Command block select, active low |
| cs1_n | input | 1 | Control block select, active low |
| da | input | 3 | Register address |
| dior_n | input | 1 | Host read strobe, active low |
| diow_n | input | 1 | Host write strobe, active low |
| dd_in | input | 16 | Host data bus, inbound |
| dd_out | output | 16 | Host data bus, outbound |
| dd_oe | output | 1 | Bus drive enable |
| dmack_n | input | 1 | DMA acknowledge, active low |
| dmarq | output | 1 | DMA request |
| intrq | output | 1 | Interrupt level |
| intrq_oe | output | 1 | Interrupt driver enable (0 = high impedance) |
| dasp_n | output | 1 | Activity indication, active low |
| pkt_byte | output | 8 | Packet byte to internal side |
| pkt_valid | output | 1 | Packet byte valid |
| pkt_ready | input | 1 | Internal side takes packet byte |
| pkt_done | input | 1 | Internal side finished the packet |
| dat_word | input | 16 | Data word from internal buffer |
| dat_valid | input | 1 | Data word valid |
| dat_ready | output | 1 | Data FIFO has room |

## Verification
The assertions assume a well-behaved host. Chip selects, address and write data are steady from a cycle before a strobe until cycles after it. Each strobe lasts at least three clocks, and dmack_n is held low for several clocks. pkt_done is pulsed only while BSY is set. The bench's access tasks set up the address and data one cycle early, hold each strobe for four or more cycles, and keep the selects for two cycles after release. It also keeps dmack_n low across the whole DMA strobe, so the synchronizer delay never overlaps a change of address.

// File: rtl/atapi_dev_port.sv
module atapi_dev_port #(
  parameter int PKT_BYTES = 12,
  parameter int DF_DEPTH  = 8,
  parameter bit DEV_ID    = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs0_n,
  input  logic        cs1_n,
  input  logic [2:0]  da,
  input  logic        dior_n,
  input  logic        diow_n,
  input  logic [15:0] dd_in,
  output logic [15:0] dd_out,
  output logic        dd_oe,
  input  logic        dmack_n,
  output logic        dmarq,
  output logic        intrq,
  output logic        intrq_oe,
  output logic        dasp_n,
  output logic [7:0]  pkt_byte,
  output logic        pkt_valid,
  input  logic        pkt_ready,
  input  logic        pkt_done,
  input  logic [15:0] dat_word,
  input  logic        dat_valid,
  output logic        dat_ready
);
  localparam int PW  = PKT_BYTES / 2;
  localparam int PIW = $clog2(PKT_BYTES);
  localparam int WCW = $clog2(PW + 1);
  localparam int AW  = $clog2(DF_DEPTH);
  localparam int CW  = $clog2(DF_DEPTH + 1);

  logic [2:0] rd_s, wr_s;
  logic [1:0] ack_s;
  logic rd_go, wr_go, dma_acc, cmd_acc, ctl_acc, dev_ok, port_acc;
  logic [7:0] feat, ireason, bcl, bch, drv, status;
  logic nien, bsy, irq_pend, pkt_full, pkt_wr, st_rd;
  logic [7:0]  pbuf [PKT_BYTES];
  logic [WCW-1:0] wcnt;
  logic [PIW-1:0] rcnt;
  logic [15:0] dmem [DF_DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic empty, drq, push, pop;
  logic [15:0] rd_val, rd_hold;

  assign rd_go    = rd_s[2] & ~rd_s[1];
  assign wr_go    = wr_s[2] & ~wr_s[1];
  assign dma_acc  = ~dmack_n;
  assign cmd_acc  = ~cs0_n & cs1_n & ~dma_acc;
  assign ctl_acc  = cs0_n & ~cs1_n & ~dma_acc;
  assign dev_ok   = (drv[4] == DEV_ID);
  assign port_acc = dma_acc | (cmd_acc & (da == 3'd0));

  assign empty     = (cnt == '0);
  assign drq       = ~empty;
  assign dat_ready = (cnt != CW'(DF_DEPTH));
  assign push      = dat_valid & dat_ready;
  assign pop       = rd_go & dev_ok & port_acc & ~empty;
  assign pkt_wr    = wr_go & dev_ok & cmd_acc & (da == 3'd0) & ~bsy;
  assign st_rd     = rd_go & dev_ok & cmd_acc & (da == 3'd7);

  assign status    = {bsy, 1'b1, 2'b00, drq, 3'b000};
  assign dasp_n    = ~(bsy | drq);
  assign intrq     = irq_pend;
  assign pkt_valid = pkt_full;
  assign pkt_byte  = pbuf[rcnt];
  assign dd_out    = rd_hold;
  assign dd_oe     = ~dior_n & dev_ok & (cmd_acc | ctl_acc | dma_acc);

  always_comb begin
    rd_val = '0;
    if (port_acc) begin
      rd_val = empty ? 16'h0000 : dmem[rp];
    end else if (cmd_acc) begin
      case (da)
        3'd2: rd_val = {8'h00, ireason};
        3'd4: rd_val = {8'h00, bcl};
        3'd5: rd_val = {8'h00, bch};
        3'd6: rd_val = {8'h00, drv};
        3'd7: rd_val = {8'h00, status};
        default: rd_val = '0;
      endcase
    end else if (ctl_acc && da == 3'd6) begin
      rd_val = {8'h00, status};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_s <= '1; wr_s <= '1; ack_s <= '1;
      rd_hold <= '0;
      feat <= '0; ireason <= '0; bcl <= '0; bch <= '0; drv <= '0;
      nien <= 1'b1; intrq_oe <= 1'b0; irq_pend <= 1'b0;
      dmarq <= 1'b0;
    end else begin
      rd_s  <= {rd_s[1:0], dior_n};
      wr_s  <= {wr_s[1:0], diow_n};
      ack_s <= {ack_s[0], dmack_n};
      if (rd_go && dev_ok) rd_hold <= rd_val;
      if (wr_go && cmd_acc) begin
        case (da)
          3'd1: feat    <= dd_in[7:0];
          3'd2: ireason <= dd_in[7:0];
          3'd4: bcl     <= dd_in[7:0];
          3'd5: bch     <= dd_in[7:0];
          3'd6: drv     <= dd_in[7:0];
          default: ;
        endcase
      end
      if (wr_go && ctl_acc && da == 3'd6) nien <= dd_in[1];
      intrq_oe <= ~nien & dev_ok;
      if (pkt_done && bsy) irq_pend <= 1'b1;
      else if (st_rd) irq_pend <= 1'b0;
      if (dmarq) begin
        if (!ack_s[1]) dmarq <= 1'b0;
      end else if (feat[0] && !empty && ack_s[1]) begin
        dmarq <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsy <= 1'b0; pkt_full <= 1'b0; wcnt <= '0; rcnt <= '0;
    end else if (pkt_done && bsy) begin
      bsy <= 1'b0; pkt_full <= 1'b0; wcnt <= '0; rcnt <= '0;
    end else begin
      if (pkt_wr) begin
        if (wcnt == WCW'(PW - 1)) begin
          bsy <= 1'b1; pkt_full <= 1'b1; wcnt <= '0; rcnt <= '0;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
      if (pkt_full && pkt_ready) begin
        if (rcnt == PIW'(PKT_BYTES - 1)) pkt_full <= 1'b0;
        else rcnt <= rcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pkt_wr) begin
      for (int i = 0; i < PW; i++) begin
        if (wcnt == WCW'(i)) begin
          pbuf[2*i]   <= dd_in[7:0];
          pbuf[2*i+1] <= dd_in[15:8];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) dmem[wp] <= dat_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/atapi_dev_port_chk.sv
module atapi_dev_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dmack_n,
  input logic       dmarq,
  input logic       intrq_oe,
  input logic       nien,
  input logic       dev_ok,
  input logic       drq,
  input logic       bsy,
  input logic       dat_ready,
  input logic       pkt_valid,
  input logic       pkt_ready,
  input logic       pkt_done,
  input logic [7:0] pkt_byte
);
  p_dmarq_waits_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dmarq) |-> $past(!dmack_n, 3));

  p_dmarq_needs_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dmarq) |-> $past(drq));

  p_irq_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intrq_oe) |-> $past(!nien && dev_ok));

  p_full_shows_drq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_ready |-> drq);

  p_pkt_only_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> bsy);

  p_pkt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready && !pkt_done) |=> (pkt_valid && $stable(pkt_byte)));
endmodule

bind atapi_dev_port atapi_dev_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dmack_n(dmack_n), .dmarq(dmarq),
  .intrq_oe(intrq_oe), .nien(nien), .dev_ok(dev_ok), .drq(drq), .bsy(bsy),
  .dat_ready(dat_ready), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .pkt_done(pkt_done), .pkt_byte(pkt_byte)
);

// File: tb/tb_atapi_dev_port.sv
module tb_atapi_dev_port;
  logic clk = 0, rst_n = 0;
  logic cs0_n = 1, cs1_n = 1, dior_n = 1, diow_n = 1, dmack_n = 1;
  logic [2:0] da = 0;
  logic [15:0] dd_in = 0, dd_out, dat_word = 0;
  logic dd_oe, dmarq, intrq, intrq_oe, dasp_n, pkt_valid, dat_ready;
  logic pkt_ready = 0, pkt_done = 0, dat_valid = 0;
  logic [7:0] pkt_byte;
  int n_chk = 0, n_fail = 0;
  logic [15:0] rv;
  logic oe;

  always #10 clk = ~clk;

  atapi_dev_port dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host(input bit rd, input bit ctl, input logic [2:0] a, input logic [15:0] wd,
                      input int hold, output logic [15:0] r, output logic o);
    @(negedge clk); cs0_n = ctl; cs1_n = ~ctl; da = a; dd_in = wd;
    @(negedge clk); if (rd) dior_n = 0; else diow_n = 0;
    repeat (hold) @(negedge clk);
    r = dd_out; o = dd_oe;
    dior_n = 1; diow_n = 1;
    repeat (2) @(negedge clk); cs0_n = 1; cs1_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input bit ctl, input logic [2:0] a, input logic [15:0] d);
    logic [15:0] r; logic o;
    host(0, ctl, a, d, 4, r, o);
  endtask

  task automatic rd(input bit ctl, input logic [2:0] a, input logic [15:0] exp, input string req);
    logic [15:0] r; logic o;
    host(1, ctl, a, 16'h0, 4, r, o);
    chk(req, r, exp);
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk); dat_valid = 1; dat_word = w;
    @(negedge clk); dat_valid = 0;
  endtask

  task automatic dma_rd(input logic [15:0] exp);
    @(negedge clk); dior_n = 0;
    repeat (5) @(negedge clk);
    chk("R8 dma data", dd_out, exp);
    chk("R8 dma drive", dd_oe, 1);
    dior_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 dmarq", dmarq, 0);
    chk("R1 intrq_oe", intrq_oe, 0);
    chk("R1 pkt_valid", pkt_valid, 0);
    chk("R1 dat_ready", dat_ready, 1);
    chk("R11 idle dasp", dasp_n, 1);
    rd(0, 7, 16'h0040, "R1 status");
  endtask

  task automatic t_regs;
    wr(0, 2, 16'hABCD); rd(0, 2, 16'h00CD, "R2 reg2");
    wr(0, 4, 16'h1234); rd(0, 4, 16'h0034, "R2 reg4");
    wr(0, 5, 16'h9956); rd(0, 5, 16'h0056, "R2 reg5");
    rd(0, 1, 16'h0000, "R2 error");
  endtask

  task automatic t_fifo;
    for (int i = 0; i < 8; i++) push(16'h1000 + 16'(i));
    chk("R12 full", dat_ready, 0);
    push(16'hDEAD);
    chk("R11 drq dasp", dasp_n, 0);
    rd(0, 7, 16'h0048, "R4 status drq");
    rd(1, 6, 16'h0048, "R4 alt status");
    host(1, 0, 0, 16'h0, 20, rv, oe);
    chk("R7 long read", rv, 16'h1000);
    chk("R12 room", dat_ready, 1);
    for (int i = 1; i < 8; i++) rd(0, 0, 16'h1000 + 16'(i), "R3 order");
    rd(0, 7, 16'h0040, "R4 empty");
    chk("R11 dasp idle", dasp_n, 1);
  endtask

  task automatic t_packet;
    int n;
    logic [7:0] got [12];
    for (int i = 0; i < 5; i++) wr(0, 0, {8'(2*i+2), 8'(2*i+1)});
    chk("R5 not yet", pkt_valid, 0);
    wr(0, 0, 16'h0C0B);
    chk("R5 ready", pkt_valid, 1);
    chk("R11 busy dasp", dasp_n, 0);
    rd(1, 6, 16'h00C0, "R6 bsy set");
    wr(0, 0, 16'hEEEE);
    n = 0;
    @(negedge clk); pkt_ready = 1;
    for (int c = 0; c < 20; c++) begin
      @(posedge clk);
      if (pkt_valid && n < 12) begin got[n] = pkt_byte; n++; end
      @(negedge clk);
    end
    pkt_ready = 0;
    chk("R5 count", n, 12);
    for (int i = 0; i < 12; i++) chk("R5 R6 byte order", got[i], 8'(i + 1));
    chk("R5 drained", pkt_valid, 0);
    rd(1, 6, 16'h00C0, "R6 bsy held");
    @(negedge clk); pkt_done = 1; @(negedge clk); pkt_done = 0;
    rd(1, 6, 16'h0040, "R6 bsy cleared");
  endtask

  task automatic t_irq;
    chk("R9 nien reset", intrq_oe, 0);
    wr(1, 6, 16'h0000);
    chk("R9 enabled", intrq_oe, 1);
    chk("R10 pending", intrq, 1);
    rd(1, 6, 16'h0040, "R10 alt read");
    chk("R10 alt keeps", intrq, 1);
    rd(0, 7, 16'h0040, "R10 status read");
    chk("R10 cleared", intrq, 0);
    wr(1, 6, 16'h0002);
    chk("R9 nien set", intrq_oe, 0);
    wr(1, 6, 16'h0000);
    wr(0, 6, 16'h0010);
    chk("R9 deselected", intrq_oe, 0);
    host(1, 0, 2, 16'h0, 4, rv, oe);
    chk("R9 no drive", oe, 0);
    wr(0, 6, 16'h0000);
    chk("R9 reselected", intrq_oe, 1);
  endtask

  task automatic t_dma;
    wr(0, 1, 16'h0001);
    push(16'hA1A1); push(16'hB2B2);
    repeat (6) @(negedge clk);
    chk("R8 request", dmarq, 1);
    repeat (10) @(negedge clk);
    chk("R8 held", dmarq, 1);
    dmack_n = 0;
    repeat (5) @(negedge clk);
    chk("R8 drop after ack", dmarq, 0);
    dma_rd(16'hA1A1);
    dmack_n = 1;
    repeat (6) @(negedge clk);
    chk("R8 more data", dmarq, 1);
    dmack_n = 0;
    repeat (5) @(negedge clk);
    dma_rd(16'hB2B2);
    dmack_n = 1;
    repeat (8) @(negedge clk);
    chk("R8 no data", dmarq, 0);
    wr(0, 1, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset;
    t_regs;
    t_fifo;
    t_packet;
    t_irq;
    t_dma;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule